// File: doc/BRIEF.md
# Four-channel DMA bus arbiter with completion-driven rotation

This block decides which of several DMA channels owns the shared bus next. Each channel raises a request line. The arbiter answers with a registered one-hot grant vector and a valid flag. The winning channel then keeps the bus for as long as it holds its busy line, so a transfer in progress is never cut short.

A mode input selects between two policies. In fixed mode the lowest-numbered requester always wins. In round-robin mode the arbiter keeps a priority list. The list changes only when the current owner pulses its completion line; that channel then moves to the back of the list. A grant on its own never changes the list. Completion pulses from channels that do not own the bus are disregarded. The list returns to ascending channel order on reset and on any change of mode.

The block carries no data and generates no addresses. Descriptor handling is also left to the channels.

Top module: `dma_chan_arbiter`

## Requirements
- R1: During synchronous active-low reset the grant vector and the valid flag are zero. After reset the priority list is ascending, with channel 0 first.
- R2: The grant vector has at most one bit set, where bit i stands for channel i. The valid flag is 1 exactly when some grant bit is set.
- R3: When no channel requests and the owner's busy line is low, the grant vector is zero after the next clock edge.
- R4: In fixed mode (mode input 0), a new grant goes to the lowest-numbered requesting channel.
- R5: The grant is registered. A request change shows on the grant only after the next rising clock edge, and a new grant only ever goes to a channel whose request was high.
- R6: While the granted channel holds its busy line high, the grant stays on it, even when a channel with higher priority requests.
- R7: In round-robin mode (mode input 1), a completion pulse from the current owner moves that channel to the lowest priority. The arbitration in that same cycle already uses the new order.
- R8: A completion pulse from a channel that is not the current owner leaves the priority list unchanged.
- R9: Granting a channel again, without a completion pulse from it, does not rotate the priority list.
- R10: A change on the mode input resets the priority list to ascending order. The decision in that cycle already uses the reset order.
- R11: In fixed mode, completion pulses have no effect on which channel is chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rr_mode_i | input | 1 | Policy select: 0 fixed, 1 round robin |
| req_i | input | N_CH | Per-channel bus request |
| busy_i | input | N_CH | Per-channel bus-busy; holds the grant while high for the owner |
| done_i | input | N_CH | Per-channel one-cycle completion pulse |
| gnt_o | output | N_CH | One-hot grant, bit i for channel i |
| gnt_valid_o | output | 1 | High when any grant bit is set |

## Verification
The bench builds the arbiter with the default N_CH of 4. With four channels, a short run of owner completions walks the priority list through several distinct rotations and then back to ascending order. This exposes any design that rotates on grants, or that takes completions from non-owners, by the channel it picks. Four channels also leave room to toggle the mode while the list is rotated. That shows the list returning to ascending order and the fixed policy ignoring completions. It also allows holding a busy owner while a higher-priority channel requests.

// File: rtl/arb_pkg.sv
// Shared types for the DMA channel arbiter.
// Assumes: the mode select is a single bit supplied by configuration logic.
package arb_pkg;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/arb_prio_order.sv
// Keeps the rotating priority list. Entry 0 is the highest priority and
// entry N_CH-1 the lowest. In round-robin mode a completion from the owner
// moves that channel to the last entry. A mode change or reset restores
// ascending order. The list for the present cycle's decision is driven out
// combinationally on order_o.
// Assumes: owner_i is one-hot or zero (it is the registered grant).
module arb_prio_order
    import arb_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  arb_mode_e                        mode_i,
    input  logic [N_CH-1:0]                  done_i,
    input  logic [N_CH-1:0]                  owner_i,
    output logic [N_CH-1:0][IDX_W-1:0]       order_o
);

    logic [N_CH-1:0][IDX_W-1:0] order_q;
    logic [N_CH-1:0][IDX_W-1:0] ident;
    logic [N_CH-1:0][IDX_W-1:0] shifted;
    logic [N_CH-1:0][IDX_W-1:0] order_nxt;
    logic [N_CH-1:0]            owner_done;
    logic [IDX_W-1:0]           done_idx;
    logic [IDX_W-1:0]           done_pos;
    logic                       mode_chg;
    logic                       do_rot;
    arb_mode_e                  mode_q;

    // Ascending reference order: entry i holds channel i.
    always_comb begin
        for (int i = 0; i < N_CH; i++) ident[i] = IDX_W'(i);
    end

    // Index of the owner that completes this cycle.
    always_comb begin
        owner_done = done_i & owner_i;
        done_idx   = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (owner_done[i]) done_idx = IDX_W'(i);
        end
    end

    // Position of the completing channel inside the current list.
    always_comb begin
        done_pos = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (order_q[i] == done_idx) done_pos = IDX_W'(i);
        end
    end

    // List with the completing channel moved to the back.
    always_comb begin
        for (int i = 0; i < N_CH - 1; i++) begin
            shifted[i] = (IDX_W'(i) < done_pos) ? order_q[i] : order_q[i+1];
        end
        shifted[N_CH-1] = done_idx;
    end

    // Select the list used for this cycle's decision.
    always_comb begin
        mode_chg = (mode_i != mode_q);
        do_rot   = (mode_i == ARB_ROUND) && !mode_chg && (|owner_done);
        if (mode_chg)    order_nxt = ident;
        else if (do_rot) order_nxt = shifted;
        else             order_nxt = order_q;
    end

    assign order_o = order_nxt;

    // Register the list and the mode seen last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= ident;
            mode_q  <= mode_i;
        end else begin
            order_q <= order_nxt;
            mode_q  <= mode_i;
        end
    end

    // ---- assertions ----
    logic [N_CH-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < N_CH; i++) seen[order_q[i]] = 1'b1;
    end

    // R7: the list stays a permutation of all channels
    a_r7_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == N_CH);

    // R7: an owner completion in steady round-robin lands that channel last
    a_r7_owner_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ARB_ROUND && mode_q == ARB_ROUND && (|(done_i & owner_i)))
        |=> order_q[N_CH-1] == $past(done_idx));

    // R8: no owner completion, no mode change -> list unchanged
    a_r8_foreign_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == mode_q && (done_i & owner_i) == '0) |=> $stable(order_q));

    // R10: a mode change restores ascending order
    a_r10_mode_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |=> order_q == ident);

    // R11: steady fixed mode never moves the list
    a_r11_fixed_static: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ARB_FIXED && mode_q == ARB_FIXED) |=> $stable(order_q));

endmodule

// File: rtl/arb_pick.sv
// Combinational winner selection. Walks the priority list from the highest
// entry down and returns a one-hot vector for the first requesting channel,
// or zero when nobody requests.
// Assumes: order_i is a permutation of the channel indices.
module arb_pick #(
    parameter int N_CH  = 4,
    parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0]            req_i,
    input  logic [N_CH-1:0][IDX_W-1:0] order_i,
    output logic [N_CH-1:0]            pick_o
);

    // Scan lowest priority first so the highest-priority hit is written last.
    always_comb begin
        pick_o = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req_i[order_i[i]]) begin
                pick_o = '0;
                pick_o[order_i[i]] = 1'b1;
            end
        end
    end

    // R2: the picker never returns more than one winner
    a_r2_pick_onehot: assert final ($onehot0(pick_o));

endmodule

// File: rtl/dma_chan_arbiter.sv
// Top of the DMA channel arbiter. Holds the registered grant and keeps it
// on a busy owner. Otherwise it loads the winner chosen against the
// priority list, which is updated in the same cycle by owner completions
// or a mode change.
// Assumes: done_i pulses for one cycle at the end of a transfer; busy_i
// of the owner is low by the cycle its completion arrives unless it
// continues.
module dma_chan_arbiter
    import arb_pkg::*;
#(
    parameter int N_CH  = 4,
    localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rr_mode_i,
    input  logic [N_CH-1:0] req_i,
    input  logic [N_CH-1:0] busy_i,
    input  logic [N_CH-1:0] done_i,
    output logic [N_CH-1:0] gnt_o,
    output logic            gnt_valid_o
);

    logic [N_CH-1:0]            gnt_q;
    logic [N_CH-1:0]            pick;
    logic [N_CH-1:0][IDX_W-1:0] order;
    logic                       hold;
    arb_mode_e                  mode;

    assign mode = arb_mode_e'(rr_mode_i);
    assign hold = |(gnt_q & busy_i);

    arb_prio_order #(.N_CH(N_CH), .IDX_W(IDX_W)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .done_i  (done_i),
        .owner_i (gnt_q),
        .order_o (order)
    );

    arb_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick (
        .req_i   (req_i),
        .order_i (order),
        .pick_o  (pick)
    );

    // Grant register: keep a busy owner, otherwise take the new winner.
    always_ff @(posedge clk) begin
        if (!rst_n)    gnt_q <= '0;
        else if (hold) gnt_q <= gnt_q;
        else           gnt_q <= pick;
    end

    assign gnt_o       = gnt_q;
    assign gnt_valid_o = |gnt_q;

    // ---- assertions ----
    // R2: grant is one-hot or zero
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));

    // R6: a busy owner keeps the bus on the next cycle
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> gnt_q == $past(gnt_q));

    // R5: a fresh grant only goes to a channel that was requesting
    a_r5_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (gnt_q == '0) || ((gnt_q & $past(req_i)) != '0));

    // R3: idle bus with no requests gives an empty grant
    a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && req_i == '0) |=> gnt_q == '0);

endmodule

// File: tb/dma_chan_arbiter_bench.sv
// Self-checking bench for dma_chan_arbiter with four channels.
module dma_chan_arbiter_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rr_mode = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] busy = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] gnt;
    logic         gnt_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_chan_arbiter #(.N_CH(N)) u_dma_chan_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .rr_mode_i   (rr_mode),
        .req_i       (req),
        .busy_i      (busy),
        .done_i      (done),
        .gnt_o       (gnt),
        .gnt_valid_o (gnt_valid)
    );

    // Vector: {rr_mode, req[3:0], busy[3:0], done[3:0], exp_gnt[3:0], tag[3:0]}
    localparam int NV = 21;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'd3 },  // R3 idle
        {1'b0, 4'b1010, 4'b0000, 4'b0000, 4'b0010, 4'd4 },  // R4 lowest index
        {1'b0, 4'b1010, 4'b0010, 4'b0000, 4'b0010, 4'd6 },  // R6 hold
        {1'b0, 4'b1011, 4'b0010, 4'b0000, 4'b0010, 4'd6 },  // R6 no preempt by ch0
        {1'b0, 4'b1001, 4'b0000, 4'b0010, 4'b0001, 4'd11},  // R11 done ignored
        {1'b0, 4'b1000, 4'b0000, 4'b0000, 4'b1000, 4'd4 },  // R4
        {1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'd3 },  // R3
        {1'b1, 4'b1111, 4'b0000, 4'b0000, 4'b0001, 4'd10},  // R10 enter rr
        {1'b1, 4'b1111, 4'b0001, 4'b0000, 4'b0001, 4'd6 },  // R6
        {1'b1, 4'b1111, 4'b0000, 4'b0001, 4'b0010, 4'd7 },  // R7 order 1230
        {1'b1, 4'b1111, 4'b0000, 4'b0100, 4'b0010, 4'd8 },  // R8 foreign done
        {1'b1, 4'b1111, 4'b0000, 4'b0010, 4'b0100, 4'd7 },  // R7 order 2301
        {1'b1, 4'b1001, 4'b0000, 4'b0100, 4'b1000, 4'd7 },  // R7 order 3012
        {1'b1, 4'b0001, 4'b0000, 4'b1000, 4'b0001, 4'd7 },  // R7 order 0123
        {1'b1, 4'b1110, 4'b0000, 4'b0001, 4'b0010, 4'd7 },  // R7 order 1230
        {1'b0, 4'b1101, 4'b0000, 4'b0000, 4'b0001, 4'd10},  // R10 back to fixed
        {1'b1, 4'b1100, 4'b0000, 4'b0001, 4'b0100, 4'd10},  // R10 to rr
        {1'b1, 4'b1000, 4'b0000, 4'b0000, 4'b1000, 4'd4 },  // R4 sole requester
        {1'b1, 4'b1111, 4'b0000, 4'b0000, 4'b0001, 4'd9 },  // R9
        {1'b1, 4'b0101, 4'b0000, 4'b0000, 4'b0001, 4'd9 },  // R9 regrant, no rotate
        {1'b1, 4'b0101, 4'b0000, 4'b0000, 4'b0001, 4'd9 }   // R9
    };

    task automatic check(input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic [N-1:0] r,
                         input logic [N-1:0] b, input logic [N-1:0] d);
        rr_mode = m; req = r; busy = b; done = d;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 gnt in reset", gnt, '0);
        check("R1 valid in reset", {3'b000, gnt_valid}, '0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample at the next one.
        for (int v = 0; v < NV; v++) begin
            logic [20:0] e;
            e = VEC[v];
            drive(e[20], e[19:16], e[15:12], e[11:8]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", e[3:0], v), gnt, e[7:4]);
            check($sformatf("R2 valid vector %0d", v), {3'b000, gnt_valid},
                  {3'b000, (e[7:4] != 4'b0000)});
        end

        // R5: registered grant, nothing moves before the edge
        drive(1'b0, 4'b0000, 4'b0000, 4'b0000);
        @(negedge clk);
        drive(1'b0, 4'b0100, 4'b0000, 4'b0000);
        #1;
        check("R5 before edge", gnt, 4'b0000);
        @(negedge clk);
        check("R5 after edge", gnt, 4'b0100);

        // R1: reset restores ascending order in round-robin mode
        drive(1'b1, 4'b1111, 4'b0000, 4'b0000);
        @(negedge clk);
        drive(1'b1, 4'b1111, 4'b0000, 4'b0000);
        @(negedge clk);
        check("R1 setup ch0", gnt, 4'b0001);
        drive(1'b1, 4'b1111, 4'b0000, 4'b0001);
        @(negedge clk);
        check("R7 setup rotate", gnt, 4'b0010);
        drive(1'b1, 4'b1111, 4'b0000, 4'b0000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears grant", gnt, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 order ascending after reset", gnt, 4'b0001);

        // R3: owner drops request and busy -> empty grant
        drive(1'b1, 4'b0000, 4'b0000, 4'b0000);
        @(negedge clk);
        check("R3 release", gnt, 4'b0000);
        check("R2 valid low", {3'b000, gnt_valid}, 4'b0000);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule